// File: doc/BRIEF.md
# Bitstream header clock-ratio selector

This block sits beside a configuration data path and watches 32-bit words of a configuration image go by. It counts the accepted words from zero and picks out two header words at fixed positions: one carries a field that marks the image as encrypted, the other carries a bit that marks it as compressed. Once the later of the two words has been seen, the block presents the clock-to-data ratio code that the configuration engine needs. This code depends on the two flags and on the configuration width chosen for the image.

A stream begins with a one-cycle start pulse. The start pulse also samples the width selection: 32-bit for a full configuration, 16-bit for partial reconfiguration. If the stream's last word arrives before the header is complete, the block raises a sticky short-stream error and gives no ratio. Words after the header pass through without effect. The block only observes the stream and never stalls it.

Top module: `hdr_ratio_sel`

## Requirements
- R1: After reset, `ratio_valid_o`, `short_err_o`, `cfg_wide_o` and `ratio_code_o` are all 0, and `word_ready_o` is 1.
- R2: `cfg_wide_o` takes the value of `wide_mode_i` sampled in the cycle where `sos_i` is high, and holds it until the next `sos_i`. A value of 1 means the 32-bit mode and 0 means the 16-bit mode.
- R3: The image counts as encrypted when bits [3:2] of word 69 (words numbered from 0) are not both 0.
- R4: The image counts as compressed when bit 1 of word 229 is 0.
- R5: The ratio code is 0 (x1), 1 (x2), 2 (x4) or 3 (x8). It is 0 when the image is neither encrypted nor compressed. A compressed image gets a base of 2, and an encrypted-only image gets a base of 1. In 32-bit mode the base is raised by one, so a compressed image gives 3 and an encrypted-only image gives 2.
- R6: `ratio_valid_o` rises on the cycle after word 229 is accepted and stays high, with a stable code, until the next `sos_i`.
- R7: When a word with `word_last_i` high is accepted with an index below 229, `short_err_o` rises on the next cycle and stays high until the next `sos_i`. `ratio_valid_o` stays 0.
- R8: Words accepted after word 229 change neither the code nor the flags. A last marker on word 229 or later raises no error.
- R9: A cycle with `sos_i` high clears `ratio_valid_o`, `short_err_o` and the word index for the next cycle. Words offered in that same cycle are not counted.
- R10: Cycles with `word_valid_i` low are ignored, whatever is on `word_data_i` and `word_last_i`. Words offered before the first `sos_i` after reset are ignored.
- R11: `ratio_code_o` is 0 whenever `ratio_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sos_i | input | 1 | Start-of-stream pulse |
| wide_mode_i | input | 1 | Width selection sampled at start (1 = 32-bit) |
| word_valid_i | input | 1 | Word offered this cycle |
| word_ready_o | output | 1 | Always 1; the block never stalls the stream |
| word_data_i | input | 32 | Stream word |
| word_last_i | input | 1 | Marks the final word of the stream |
| ratio_code_o | output | 2 | Selected ratio code |
| cfg_wide_o | output | 1 | Latched width setting |
| ratio_valid_o | output | 1 | Ratio code is final |
| short_err_o | output | 1 | Stream ended before the header was complete |

## Verification
The hardest situations to reach from the ports are the ones that depend on word position: a last marker exactly one word before the compression word, or exactly on it. The bench builds streams of chosen lengths, with idle gaps inserted at random. Each stream ends at index 228, 229 or beyond, and the two flag words are forced to chosen values while every other word is random. A restart in the middle of a stream and traffic before the first start pulse are driven directly.

// File: rtl/hdr_ratio_pkg.sv
package hdr_ratio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DONE = 2'd2,
    ST_ERR  = 2'd3
  } hdr_state_e;

  localparam logic [1:0] RATIO_X1 = 2'd0;
  localparam logic [1:0] RATIO_X2 = 2'd1;
  localparam logic [1:0] RATIO_X4 = 2'd2;
  localparam logic [1:0] RATIO_X8 = 2'd3;
endpackage

// File: rtl/hdr_word_counter.sv
module hdr_word_counter #(
  parameter int unsigned LIMIT = 230,
  parameter int unsigned CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          adv_i,
  output logic [CW-1:0] idx_o
);
  logic [CW-1:0] idx_q, idx_d;
  logic          at_limit;

  assign at_limit = (idx_q == CW'(LIMIT));

  always_comb begin
    idx_d = idx_q;
    if (clr_i)                   idx_d = '0;
    else if (adv_i && !at_limit) idx_d = idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  assign idx_o = idx_q;

  // R8: index saturates and never runs past the limit
  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= CW'(LIMIT));
endmodule

// File: rtl/hdr_flag_capture.sv
module hdr_flag_capture #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned CW      = 8,
  parameter int unsigned ENC_IDX = 69,
  parameter int unsigned CMP_IDX = 229,
  parameter int unsigned ENC_LSB = 2,
  parameter int unsigned ENC_W   = 2,
  parameter int unsigned CMP_BIT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              adv_i,
  input  logic [CW-1:0]     idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              enc_o,
  output logic              cmp_o
);
  logic enc_q, enc_d, cmp_q, cmp_d;
  logic enc_hit, cmp_hit;

  assign enc_hit = adv_i && (idx_i == CW'(ENC_IDX));
  assign cmp_hit = adv_i && (idx_i == CW'(CMP_IDX));

  always_comb begin
    enc_d = enc_q;
    cmp_d = cmp_q;
    if (clr_i) begin
      enc_d = 1'b0;
      cmp_d = 1'b0;
    end else begin
      if (enc_hit) enc_d = |data_i[ENC_LSB +: ENC_W];
      if (cmp_hit) cmp_d = ~data_i[CMP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      enc_q <= enc_d;
      cmp_q <= cmp_d;
    end
  end

  assign enc_o = enc_q;
  assign cmp_o = cmp_q;

  // R3: encryption flag moves only on a start or on the encryption word
  assert_enc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i && !enc_hit |=> $stable(enc_q));
endmodule

// File: rtl/hdr_ratio_encode.sv
module hdr_ratio_encode
  import hdr_ratio_pkg::*;
(
  input  logic       wide_i,
  input  logic       enc_i,
  input  logic       cmp_i,
  output logic [1:0] code_o
);
  logic [1:0] base;

  always_comb begin
    if (cmp_i)      base = RATIO_X4;
    else if (enc_i) base = RATIO_X2;
    else            base = RATIO_X1;
    if ((enc_i || cmp_i) && wide_i) code_o = base + 2'd1;
    else                            code_o = base;
  end
endmodule

// File: rtl/hdr_ratio_sel.sv
module hdr_ratio_sel
  import hdr_ratio_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ENC_IDX = 69,
  parameter int unsigned CMP_IDX = 229
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sos_i,
  input  logic              wide_mode_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  input  logic [DATA_W-1:0] word_data_i,
  input  logic              word_last_i,
  output logic [1:0]        ratio_code_o,
  output logic              cfg_wide_o,
  output logic              ratio_valid_o,
  output logic              short_err_o
);
  localparam int unsigned LIMIT = CMP_IDX + 1;
  localparam int unsigned CW    = $clog2(LIMIT + 1);

  hdr_state_e    st_q, st_d;
  logic          wide_q, wide_d;
  logic          acc, adv;
  logic [CW-1:0] idx;
  logic          enc_f, cmp_f;
  logic [1:0]    code_raw;

  assign word_ready_o = 1'b1;
  assign acc = word_valid_i && word_ready_o;
  assign adv = acc && (st_q == ST_HDR) && !sos_i;

  hdr_word_counter #(.LIMIT(LIMIT), .CW(CW)) cnt_i (
    .clk(clk), .rst_n(rst_n), .clr_i(sos_i), .adv_i(adv), .idx_o(idx)
  );

  hdr_flag_capture #(
    .DATA_W(DATA_W), .CW(CW), .ENC_IDX(ENC_IDX), .CMP_IDX(CMP_IDX),
    .ENC_LSB(2), .ENC_W(2), .CMP_BIT(1)
  ) cap_i (
    .clk(clk), .rst_n(rst_n), .clr_i(sos_i), .adv_i(adv), .idx_i(idx),
    .data_i(word_data_i), .enc_o(enc_f), .cmp_o(cmp_f)
  );

  hdr_ratio_encode enc_i (
    .wide_i(wide_q), .enc_i(enc_f), .cmp_i(cmp_f), .code_o(code_raw)
  );

  always_comb begin
    st_d = st_q;
    if (sos_i) begin
      st_d = ST_HDR;
    end else if (adv) begin
      if (idx == CW'(CMP_IDX)) st_d = ST_DONE;
      else if (word_last_i)    st_d = ST_ERR;
    end
  end

  always_comb begin
    wide_d = wide_q;
    if (sos_i) wide_d = wide_mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wide_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wide_q <= wide_d;
    end
  end

  assign ratio_valid_o = (st_q == ST_DONE);
  assign short_err_o   = (st_q == ST_ERR);
  assign cfg_wide_o    = wide_q;
  assign ratio_code_o  = ratio_valid_o ? code_raw : RATIO_X1;

  // R7: a stream ends either with a ratio or with an error, never both
  assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ratio_valid_o && short_err_o));

  // R6: once valid, result holds until the next start
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid_o && !sos_i |=> ratio_valid_o && $stable(ratio_code_o));

  // R6: valid only rises right after an accepted word
  assert_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_valid_o) |-> $past(word_valid_i && !sos_i));

  // R11: no code without a valid result
  assert_idle_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ratio_valid_o |-> ratio_code_o == RATIO_X1);

  // R5: the x8 code only appears in 32-bit mode
  assert_x8_wide_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_valid_o && ratio_code_o == RATIO_X8 |-> cfg_wide_o);

  // R9: a start clears both outcomes
  assert_sos_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sos_i |=> !ratio_valid_o && !short_err_o);
endmodule

// File: tb/hdr_ratio_sel_tb_top.sv
module hdr_ratio_sel_tb_top;
  logic        clk;
  logic        rst_n;
  logic        sos, wide, vld, lst;
  logic [31:0] dat;
  logic        rdy, wide_o, valid_o, err_o;
  logic [1:0]  code_o;
  int          checks;
  int          fails;
  bit          finished;

  hdr_ratio_sel dut_i (
    .clk(clk), .rst_n(rst_n), .sos_i(sos), .wide_mode_i(wide),
    .word_valid_i(vld), .word_ready_o(rdy), .word_data_i(dat),
    .word_last_i(lst), .ratio_code_o(code_o), .cfg_wide_o(wide_o),
    .ratio_valid_o(valid_o), .short_err_o(err_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [1:0] exp_code(bit w, bit e, bit c);
    logic [1:0] b;
    if (!e && !c) return 2'd0;
    b = c ? 2'd2 : 2'd1;
    return w ? b + 2'd1 : b;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_word(logic [31:0] d, logic l);
    int gap = $urandom_range(0, 2);
    for (int g = 0; g < gap; g++) begin
      vld = 1'b0; dat = $urandom; lst = 1'($urandom_range(0, 1));
      @(negedge clk);
    end
    vld = 1'b1; dat = d; lst = l;
    @(negedge clk);
    vld = 1'b0; lst = 1'b0;
  endtask

  task automatic start(bit w);
    sos = 1'b1; wide = w;
    @(negedge clk);
    sos = 1'b0; wide = 1'($urandom_range(0, 1));
  endtask

  // n words, last marker on final word when endl
  task automatic stream(int n, bit w, logic [1:0] e2, logic cb, bit endl);
    bit e = (e2 != 2'b00);
    bit c = !cb;
    logic [31:0] d;
    start(w);
    chk("R2 width latched", wide_o, w);
    for (int i = 0; i < n; i++) begin
      d = $urandom;
      if (i == 69)  d[3:2] = e2;
      if (i == 229) d[1] = cb;
      if (i == 228) begin
        chk("R6 not valid before word 229", valid_o, 0);
        chk("R11 code zero while not valid", code_o, 0);
      end
      put_word(d, endl && (i == n - 1));
      if (i == 229) begin
        chk("R6 valid after word 229", valid_o, 1);
        chk("R5 R3 R4 ratio code", code_o, exp_code(w, e, c));
      end
    end
    repeat (2) @(negedge clk);
    if (n >= 230) begin
      chk("R8 valid held after extra words", valid_o, 1);
      chk("R8 code unchanged after extra words", code_o, exp_code(w, e, c));
      chk("R8 no error on late last", err_o, 0);
    end else if (endl) begin
      chk("R7 short stream error", err_o, 1);
      chk("R7 no ratio on short stream", valid_o, 0);
      chk("R11 code zero on error", code_o, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    checks = 0; fails = 0; finished = 0;
    sos = 0; wide = 0; vld = 0; lst = 0; dat = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", valid_o, 0);
    chk("R1 error after reset", err_o, 0);
    chk("R1 code after reset", code_o, 0);
    chk("R1 width after reset", wide_o, 0);
    chk("R1 ready after reset", rdy, 1);

    // R10: traffic before any start is ignored
    for (int i = 0; i < 240; i++) put_word($urandom, i == 3);
    chk("R10 no error before start", err_o, 0);
    chk("R10 no valid before start", valid_o, 0);

    // R3 R4 R5 directed: all flag combinations at both widths
    for (int w = 0; w < 2; w++)
      for (int e = 0; e < 4; e++)
        for (int c = 0; c < 2; c++)
          stream(230, 1'(w), 2'(e), 1'(c), 1'b1);

    // R7 boundary: last on word 228, and a very short stream
    stream(229, 1'b1, 2'b01, 1'b0, 1'b1);
    stream(5, 1'b0, 2'b00, 1'b1, 1'b1);
    // R8: long stream, last well after header
    stream(260, 1'b1, 2'b10, 1'b1, 1'b1);

    // R9: restart mid-stream, then a clean stream
    stream(120, 1'b1, 2'b11, 1'b0, 1'b0);
    start(1'b0);
    chk("R9 valid cleared by start", valid_o, 0);
    chk("R9 error cleared by start", err_o, 0);
    stream(230, 1'b0, 2'b00, 1'b1, 1'b1);
    chk("R9 clean stream after restart", code_o, 0);

    // R9: start after error clears it; word with start not counted
    stream(10, 1'b1, 2'b00, 1'b0, 1'b1);
    sos = 1'b1; wide = 1'b1; vld = 1'b1; lst = 1'b1; dat = '0;
    @(negedge clk);
    sos = 1'b0; vld = 1'b0; lst = 1'b0;
    chk("R9 word with start not counted", err_o, 0);
    for (int i = 0; i < 230; i++) begin
      logic [31:0] d = $urandom;
      if (i == 69)  d[3:2] = 2'b10;
      if (i == 229) d[1] = 1'b1;
      put_word(d, 1'b0);
    end
    chk("R9 index restarted at start", code_o, 2'd2);

    // random streams
    for (int k = 0; k < 24; k++) begin
      int sel = $urandom_range(0, 3);
      int n = (sel == 0) ? $urandom_range(1, 229) :
              (sel == 1) ? 229 : (sel == 2) ? 230 : $urandom_range(231, 300);
      stream(n, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
             1'($urandom_range(0, 1)), 1'b1);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule